// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Unit

This block holds the exception and rounding part of a floating-point status register. Each time the arithmetic datapath finishes an operation, it pulses a completion strobe and presents the five IEEE exception flags. The unit captures these flags as the current exceptions and compares them with the trap-enable mask. If any enabled exception is present, it requests an IEEE trap. If not, it adds the flags to the accrued exceptions. The datapath itself is outside this block.

Software reads the register as one 32-bit word. The read value also carries the live condition code from the compare logic and a fixed version number. Software writes the register in one of two ways: a full write, or a partial write that leaves the trap type as it is. The unit decodes the rounding-direction field into a one-hot rounding selection that the datapath consumes.

Top module: `fp_exc_status`

## Requirements
- R1: When `op_done` is high, `op_flags` goes one-to-one into the current-exception field `rd_data[4:0]`. The bit order is invalid=bit4, overflow=bit3, underflow=bit2, divide-by-zero=bit1, inexact=bit0. The field is visible the cycle after the strobe.
- R2: If `op_flags & mask` is nonzero at completion, with the mask in `rd_data[27:23]`, then `trap_req` is high in the next cycle. In that cycle the trap type `rd_data[16:14]` reads 3'd1 (IEEE exception) and the accrued field `rd_data[9:5]` keeps its old value.
- R3: If a completion has no enabled exception, the accrued field becomes its old value OR the flags, and the trap type becomes 0.
- R4: A completion with all flags zero clears the current-exception field and the trap type, leaves the accrued field unchanged and raises no trap.
- R5: `rnd_sel` is one-hot and decodes rounding field `rd_data[31:30]` as follows: 0 → bit0 (nearest-even), 1 → bit1 (toward zero), 2 → bit2 (toward +inf), 3 → bit3 (toward −inf). Any value not recognised selects toward zero.
- R6: A full write (`wr_en`=1, `wr_kind`=0) loads the rounding [31:30], mask [27:23], trap type [16:14], accrued [9:5] and current [4:0] fields from `wr_data`.
- R7: A partial write (`wr_kind`=1) loads rounding, mask, accrued and current fields and keeps the existing trap type.
- R8: `rd_data[11:10]` always shows `fcc_in`, `rd_data[19:17]` always shows the parameter `VERSION`, and all other bits read zero. Writes do not change the version or the reserved bits.
- R9: A synchronous active-low reset clears every field and selects nearest-even rounding. `trap_req` is low after reset.
- R10: If a write and a completion fall in the same cycle, the written values win in the register. `trap_req` is still decided from the flags and the mask that was in force before the write.
- R11: `trap_req` is a single-cycle pulse. It is high only in the cycle right after a completion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_done | input | 1 | Operation completion strobe |
| op_flags | input | 5 | IEEE flags of the completing operation |
| wr_en | input | 1 | Software register write |
| wr_kind | input | 1 | 0 = full write, 1 = write keeping trap type |
| wr_data | input | 32 | Write data |
| fcc_in | input | 2 | Condition code merged into reads |
| rd_data | output | 32 | Assembled register read value |
| trap_req | output | 1 | One-cycle IEEE trap request |
| rnd_sel | output | 4 | One-hot rounding selection |

## Verification
A software write and an operation completion can land in the same clock. The bench provokes this by raising `wr_en` and `op_done` on the same edge. It picks the mask before the write and the mask in the write data so that the trap decision under the old mask differs from the decision under the new one. The result is judged on two things: the register read must equal the written word, and `trap_req` must follow the old mask alone. Outside this case, every flag pattern is swept under several masks, and the bench checks each result against a running model of the accrued field.

// File: rtl/fpx_pkg.sv
// Shared field widths, encodings and types for the exception status unit.
// Assumes a 32-bit status word with the field positions fixed below.
package fpx_pkg;
    localparam int EXC_W  = 5;
    localparam int RND_W  = 2;
    localparam int TT_W   = 3;
    localparam int CC_W   = 2;
    localparam int WORD_W = 32;

    // Field positions (low bit of each field) in the status word.
    localparam int POS_CUR = 0;
    localparam int POS_ACC = 5;
    localparam int POS_CC  = 10;
    localparam int POS_TT  = 14;
    localparam int POS_VER = 17;
    localparam int POS_MSK = 23;
    localparam int POS_RND = 30;

    localparam logic [TT_W-1:0] TT_NONE = 3'd0;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    typedef enum logic [RND_W-1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_UP   = 2'd2,
        RND_DOWN = 2'd3
    } rnd_dir_e;

    typedef struct packed {
        logic [RND_W-1:0] rnd;
        logic [EXC_W-1:0] msk;
        logic [TT_W-1:0]  tt;
        logic [EXC_W-1:0] acc;
        logic [EXC_W-1:0] cur;
    } stat_t;
endpackage

// File: rtl/fpx_exc_eval.sv
// Combinational evaluation of a completing operation's flags.
// Produces the next current/accrued/trap-type values and the trap decision.
// Assumes flags arrive in the order invalid..inexact on bits 4..0.
module fpx_exc_eval
    import fpx_pkg::*;
(
    input  logic [EXC_W-1:0] flags,
    input  logic [EXC_W-1:0] msk,
    input  logic [EXC_W-1:0] acc_old,
    output logic [EXC_W-1:0] cur_nxt,
    output logic [EXC_W-1:0] acc_nxt,
    output logic [TT_W-1:0]  tt_nxt,
    output logic             trap_hit
);
    // Decide trap versus accrue for the current flag set.
    always_comb begin
        cur_nxt  = flags;
        trap_hit = |(flags & msk);
        if (trap_hit) begin
            acc_nxt = acc_old;
            tt_nxt  = TT_IEEE;
        end else begin
            acc_nxt = acc_old | flags;
            tt_nxt  = TT_NONE;
        end
    end
endmodule

// File: rtl/fpx_rnd_decode.sv
// Decodes the rounding-direction field into a one-hot selection.
// Assumes an unrecognised code must fall back to toward-zero.
module fpx_rnd_decode
    import fpx_pkg::*;
(
    input  logic [RND_W-1:0] rnd,
    output logic [3:0]       sel
);
    // Map each direction code to its selection bit.
    always_comb begin
        case (rnd)
            RND_NEAR: sel = 4'b0001;
            RND_ZERO: sel = 4'b0010;
            RND_UP:   sel = 4'b0100;
            RND_DOWN: sel = 4'b1000;
            default:  sel = 4'b0010;
        endcase
    end
endmodule

// File: rtl/fp_exc_status.sv
// Floating-point exception status and trap unit.
// Holds rounding, trap mask, trap type, accrued and current exception
// fields; reacts to completion flags; supports full and trap-type-keeping
// software writes. Assumes a write in the same cycle as a completion wins
// in the register while the trap decision uses the pre-write mask.
module fp_exc_status
    import fpx_pkg::*;
#(
    parameter logic [TT_W-1:0] VERSION = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_done,
    input  logic [EXC_W-1:0]  op_flags,
    input  logic              wr_en,
    input  logic              wr_kind,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [CC_W-1:0]   fcc_in,
    output logic [WORD_W-1:0] rd_data,
    output logic              trap_req,
    output logic [3:0]        rnd_sel
);
    stat_t            st_q;
    logic [EXC_W-1:0] ev_cur, ev_acc;
    logic [TT_W-1:0]  ev_tt;
    logic             ev_trap;
    stat_t            wr_st;
    logic             unused_wr_bits;

    fpx_exc_eval u_eval (
        .flags   (op_flags),
        .msk     (st_q.msk),
        .acc_old (st_q.acc),
        .cur_nxt (ev_cur),
        .acc_nxt (ev_acc),
        .tt_nxt  (ev_tt),
        .trap_hit(ev_trap)
    );

    fpx_rnd_decode u_rnd (
        .rnd(st_q.rnd),
        .sel(rnd_sel)
    );

    // Slice the write word into fields; trap type kept for the partial write.
    always_comb begin
        wr_st.rnd = wr_data[POS_RND +: RND_W];
        wr_st.msk = wr_data[POS_MSK +: EXC_W];
        wr_st.acc = wr_data[POS_ACC +: EXC_W];
        wr_st.cur = wr_data[POS_CUR +: EXC_W];
        wr_st.tt  = wr_kind ? st_q.tt : wr_data[POS_TT +: TT_W];
    end

    assign unused_wr_bits = ^{wr_data[29:28], wr_data[22:17], wr_data[13:10]};

    // Status register update: reset, then write, then completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (wr_en) begin
            st_q <= wr_st;
        end else if (op_done) begin
            st_q.cur <= ev_cur;
            st_q.acc <= ev_acc;
            st_q.tt  <= ev_tt;
        end
    end

    // One-cycle trap request following an enabled exception.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_req <= 1'b0;
        else        trap_req <= op_done & ev_trap;
    end

    // Assemble the read word with condition code and version merged in.
    always_comb begin
        rd_data = '0;
        rd_data[POS_RND +: RND_W] = st_q.rnd;
        rd_data[POS_MSK +: EXC_W] = st_q.msk;
        rd_data[POS_VER +: TT_W]  = VERSION;
        rd_data[POS_TT  +: TT_W]  = st_q.tt;
        rd_data[POS_CC  +: CC_W]  = fcc_in;
        rd_data[POS_ACC +: EXC_W] = st_q.acc;
        rd_data[POS_CUR +: EXC_W] = st_q.cur;
    end

    // A trap request only follows a completion strobe.
    p_trap_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_done));

    // A trap without a colliding write shows IEEE trap type and keeps accrued.
    p_trap_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !$past(wr_en)) |-> (st_q.tt == TT_IEEE && st_q.acc == $past(st_q.acc)));

    // Without a write, accrued bits never drop.
    p_acc_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((st_q.acc & $past(st_q.acc)) == $past(st_q.acc)));

    // A flagless completion clears current and trap type and raises no trap.
    p_noflag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_flags == '0 && !wr_en) |=> (st_q.cur == '0 && st_q.tt == TT_NONE && !trap_req));

    // Rounding selection is always one-hot.
    p_rnd_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(rnd_sel));

    // A partial write keeps the trap type.
    p_keep_tt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind) |=> $stable(st_q.tt));
endmodule

// File: tb/fp_exc_status_tb_top.sv
// Self-checking bench: sweeps every flag pattern under several masks against
// a bench-side model, plus writes, reads, rounding and collision cases.
module fp_exc_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_done;
    logic [4:0]  op_flags;
    logic        wr_en;
    logic        wr_kind;
    logic [31:0] wr_data;
    logic [1:0]  fcc_in;
    logic [31:0] rd_data;
    logic        trap_req;
    logic [3:0]  rnd_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model of the register fields.
    logic [1:0] m_rnd;
    logic [4:0] m_msk, m_acc, m_cur;
    logic [2:0] m_tt;

    localparam logic [2:0] VER = 3'd5;

    always #2.5 clk = ~clk;

    fp_exc_status #(.VERSION(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_data(wr_data), .fcc_in(fcc_in),
        .rd_data(rd_data), .trap_req(trap_req), .rnd_sel(rnd_sel)
    );

    function automatic logic [31:0] exp_word();
        return {m_rnd, 2'b00, m_msk, 3'b000, VER, m_tt, 2'b00, fcc_in, m_acc, m_cur};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(logic [4:0] f);
        logic exp_trap;
        @(negedge clk);
        op_done = 1'b1; op_flags = f;
        exp_trap = |(f & m_msk);
        @(negedge clk);
        op_done = 1'b0;
        m_cur = f;
        if (exp_trap) m_tt = 3'd1;
        else begin m_acc = m_acc | f; m_tt = 3'd0; end
        chk(exp_trap ? "R2 trap" : (f == 0 ? "R4 noflag" : "R3 accrue"), {31'd0, trap_req}, {31'd0, exp_trap});
        chk("R1 status word after op", rd_data, exp_word());
        @(negedge clk);
        chk("R11 trap pulse ends", {31'd0, trap_req}, 32'd0);
    endtask

    task automatic do_wr(logic kind, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = kind; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_rnd = d[31:30]; m_msk = d[27:23]; m_acc = d[9:5]; m_cur = d[4:0];
        if (!kind) m_tt = d[16:14];
        chk(kind ? "R7 partial write" : "R6 full write", rd_data, exp_word());
    endtask

    function automatic logic [31:0] mk(logic [1:0] r, logic [4:0] m, logic [2:0] t,
                                       logic [4:0] a, logic [4:0] c);
        return {r, 2'b11, m, 3'b111, 3'b111, t, 4'b1111, a, c};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_done = 0; op_flags = 0; wr_en = 0; wr_kind = 0;
        wr_data = 0; fcc_in = 2'd0;
        m_rnd = 0; m_msk = 0; m_acc = 0; m_cur = 0; m_tt = 0;
        repeat (3) @(negedge clk);
        chk("R9 reset word", rd_data, {12'd0, VER, 17'd0});
        chk("R9 reset rounding", {28'd0, rnd_sel}, 32'h1);
        chk("R9 reset trap", {31'd0, trap_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R3/R4: all flag patterns under several masks.
        for (int mi = 0; mi < 7; mi++) begin
            logic [4:0] msk;
            msk = (mi == 0) ? 5'h00 : (mi == 1) ? 5'h1f : 5'(1 << (mi - 2));
            do_wr(1'b0, mk(2'd0, msk, 3'd0, 5'd0, 5'd0));
            for (int f = 0; f < 32; f++) do_op(5'(f));
        end

        // R5: rounding decode for every code.
        for (int r = 0; r < 4; r++) begin
            do_wr(1'b0, mk(2'(r), 5'd0, 3'd0, 5'd0, 5'd0));
            chk("R5 rounding select", {28'd0, rnd_sel}, 32'(1 << r));
        end

        // R6/R7: full write sets trap type; partial write keeps it.
        do_wr(1'b0, mk(2'd2, 5'h0a, 3'd6, 5'h11, 5'h03));
        do_wr(1'b1, mk(2'd1, 5'h15, 3'd2, 5'h0e, 5'h1c));
        chk("R7 trap type kept", {29'd0, rd_data[16:14]}, 32'd6);
        do_wr(1'b0, mk(2'd3, 5'h00, 3'd1, 5'h1f, 5'h00));

        // R8: condition code and version merged into reads.
        for (int c = 0; c < 4; c++) begin
            fcc_in = 2'(c);
            #1;
            chk("R8 read merge", rd_data, exp_word());
        end

        // R10: write collides with a trapping completion (old mask traps).
        do_wr(1'b0, mk(2'd0, 5'h10, 3'd0, 5'd0, 5'd0));
        @(negedge clk);
        op_done = 1; op_flags = 5'h10; wr_en = 1; wr_kind = 0;
        wr_data = mk(2'd1, 5'h00, 3'd0, 5'h03, 5'h00);
        @(negedge clk);
        op_done = 0; wr_en = 0;
        m_rnd = 2'd1; m_msk = 0; m_tt = 0; m_acc = 5'h03; m_cur = 0;
        chk("R10 collision trap from old mask", {31'd0, trap_req}, 32'd1);
        chk("R10 collision write wins", rd_data, exp_word());

        // R10: old mask clear, new mask set: no trap.
        @(negedge clk);
        op_done = 1; op_flags = 5'h1f; wr_en = 1; wr_kind = 1;
        wr_data = mk(2'd0, 5'h1f, 3'd4, 5'h00, 5'h01);
        @(negedge clk);
        op_done = 0; wr_en = 0;
        m_rnd = 0; m_msk = 5'h1f; m_acc = 0; m_cur = 5'h01;
        chk("R10 collision no trap", {31'd0, trap_req}, 32'd0);
        chk("R10 collision partial write wins", rd_data, exp_word());

        // R9: reset again after activity.
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        m_rnd = 0; m_msk = 0; m_acc = 0; m_cur = 0; m_tt = 0;
        chk("R9 reset after use", rd_data, exp_word());

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule